// File: doc/BRIEF.md
# Sync clock selector and divider

This block supplies the switching-cycle timebase for a buck-boost converter's digital controller and turns one shared mode pin into operating flags. The pin can carry three things: a free-running external clock, a steady high level or a steady low level. The block runs on the internal reference clock. It synchronizes the pin and counts the pin's rising edges over fixed windows of reference cycles to decide whether a clock is present. It also takes a majority vote over recent samples to find the pin's steady level.

One divide-by-22 counter produces a one-cycle `cycle_tick` per switching cycle. With the internal timebase it counts reference cycles, which gives about 591 kHz from 13 MHz. With the external timebase it counts synchronized pin edges, so the switching rate is exactly the external rate over 22. A change of timebase is applied only when a tick is issued, so no switching cycle is cut short.

A steady high pin forces PWM-only regulation. A steady low pin allows automatic PWM/PFM choice. Whenever an external clock is detected or in use, PFM is forbidden. The flags and the tick are plain level and pulse outputs with no handshake. The consumer cannot stall the tick, so it must accept every pulse.

Top module: `sync_tbase_sel`

## Requirements
- R1: While `rst_n` is low and right after it rises, `cycle_tick`, `ext_clk_active` and `pwm_only` are 0 and `pfm_allowed` is 1. The divider count starts at 0 on the internal timebase.
- R2: On the internal timebase the divider advances once per clock. `cycle_tick` is a one-clock pulse every 22 clocks, first seen high after the 22nd rising clock edge following reset release. No two ticks are ever closer than 22 clocks.
- R3: `sync_pin` passes through two flip-flops before use. A rising edge is counted in the clock where the second stage holds 1 and the delayed copy behind it holds 0.
- R4: The reference clocks form back-to-back windows of 64 cycles, starting at reset. At the last cycle of each window the clock-present decision is updated to 1 if at least 4 synchronized rising edges fell in that window, and to 0 otherwise. It holds that value until the next window end. A clock with exactly 4 edges per window counts as present.
- R5: The steady level is the majority of the last three synchronized samples. A steady high level forces `pwm_only`=1 and `pfm_allowed`=0.
- R6: With the pin steady low, no clock detected and the internal timebase selected, `pwm_only`=0 and `pfm_allowed`=1.
- R7: On the external timebase the divider advances once per synchronized rising edge. A tick is issued on every 22nd edge, so the tick spacing is 22 times the external period.
- R8: The selected timebase changes only in the clock in which a tick is issued. It takes the clock-present decision in force at that edge.
- R9: If the external timebase is selected and the clock-present decision has fallen to 0, the divider advances on every reference clock. The current cycle therefore ends and the timebase returns to internal.
- R10: `pfm_allowed` is 0 and `pwm_only` is 1 whenever a clock is detected or the external timebase is selected. `pfm_allowed` is always the complement of `pwm_only`.
- R11: `ext_clk_active` is 1 exactly when the external timebase is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin | input | 1 | Shared mode pin: external clock, steady high or steady low (asynchronous) |
| cycle_tick | output | 1 | One-clock pulse at each switching-cycle boundary |
| ext_clk_active | output | 1 | External timebase currently drives the divider |
| pwm_only | output | 1 | PWM regulation forced |
| pfm_allowed | output | 1 | Automatic PWM/PFM choice permitted |

## Verification
Some properties are checked on every cycle by assertions. Ticks are single pulses and never arrive closer than 22 clocks apart. The timebase changes only on a tick and only towards the current detection result. The detection flag moves only at window ends. PFM stays forbidden while a clock is seen or selected. Other behaviours need the bench's scenarios against its reference model: the exact tick spacing for each pin pattern, the threshold case of exactly four edges per window against a slower clock, the return to the internal timebase once the clock stops, and the steady-high and steady-low flags.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic {
    TB_INT = 1'b0,
    TB_EXT = 1'b1
  } tbase_e;
endpackage

// File: rtl/sts_pin_sync.sv
// Synchronizes the shared mode pin, flags rising edges and votes on its level.
module sts_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic level_high
);
  logic [STAGES:0] chain;
  logic [2:0]      vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      vote  <= '0;
    end else begin
      chain <= {chain[STAGES-1:0], pin_async};
      vote  <= {vote[1:0], chain[STAGES-1]};
    end
  end

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  assign rise       = chain[STAGES-1] & ~chain[STAGES];
  assign level_high = (vote[0] & vote[1]) | (vote[0] & vote[2]) | (vote[1] & vote[2]);
endmodule

// File: rtl/sts_activity.sv
// Counts synchronized edges per window of reference cycles.
module sts_activity #(
  parameter int WIN       = 64,
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic active
);
  localparam int WW = $clog2(WIN);
  localparam int EW = $clog2(MIN_EDGES + 1);

  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic [EW:0]   sum;
  logic          win_end;
  logic          enough;

  assign win_end = (win_cnt == WW'(WIN - 1));
  assign sum     = {1'b0, edge_cnt} + {{EW{1'b0}}, rise};
  assign enough  = (sum >= (EW+1)'(MIN_EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      active   <= 1'b0;
    end else if (win_end) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      active   <= enough;
    end else begin
      win_cnt  <= win_cnt + WW'(1);
      edge_cnt <= enough ? EW'(MIN_EDGES) : sum[EW-1:0];
    end
  end
endmodule

// File: rtl/sts_divider.sv
// Switching-cycle divider with tick-aligned timebase selection.
module sts_divider
  import sts_pkg::*;
#(
  parameter int DIV = 22
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise,
  input  logic   active,
  output logic   tick,
  output tbase_e src
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt;
  logic          adv;
  logic          last;

  // external: step on edges; if the clock vanished, finish on the reference
  assign adv  = (src == TB_INT) | rise | ~active;
  assign last = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
      src  <= TB_INT;
    end else begin
      tick <= 1'b0;
      if (adv) begin
        if (last) begin
          cnt  <= '0;
          tick <= 1'b1;
          src  <= active ? TB_EXT : TB_INT;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sync_tbase_sel.sv
module sync_tbase_sel
  import sts_pkg::*;
#(
  parameter int DIV         = 22,
  parameter int WIN         = 64,
  parameter int MIN_EDGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_pin,
  output logic cycle_tick,
  output logic ext_clk_active,
  output logic pwm_only,
  output logic pfm_allowed
);
  logic   pin_rise;
  logic   level_high;
  logic   det_active;
  tbase_e src;

  sts_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_async  (sync_pin),
    .rise       (pin_rise),
    .level_high (level_high)
  );

  sts_activity #(.WIN(WIN), .MIN_EDGES(MIN_EDGES)) u_act (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (pin_rise),
    .active (det_active)
  );

  sts_divider #(.DIV(DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (pin_rise),
    .active (det_active),
    .tick   (cycle_tick),
    .src    (src)
  );

  assign ext_clk_active = (src == TB_EXT);
  assign pwm_only       = ext_clk_active | det_active | level_high;
  assign pfm_allowed    = ~pwm_only;
endmodule

// File: rtl/sync_tbase_sel_chk.sv
module sync_tbase_sel_chk #(
  parameter int DIV = 22,
  parameter int WIN = 64
) (
  input logic clk,
  input logic rst_n,
  input logic cycle_tick,
  input logic ext_clk_active,
  input logic pwm_only,
  input logic pfm_allowed,
  input logic det_active
);
  localparam int WW = $clog2(WIN);

  logic [WW-1:0] win_c;
  logic [15:0]   gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_c <= '0;
      gap   <= '0;
    end else begin
      win_c <= (win_c == WW'(WIN - 1)) ? '0 : win_c + WW'(1);
      if (cycle_tick)          gap <= '0;
      else if (gap != 16'hFFFF) gap <= gap + 16'd1;
    end
  end

  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick |=> !cycle_tick);

  a_r2_no_short_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick |-> (gap >= 16'(DIV - 1)));

  a_r4_window_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(det_active) |-> $past(win_c == WW'(WIN - 1)));

  a_r8_switch_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_clk_active) |-> cycle_tick);

  a_r8_switch_follows_detect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_clk_active) |-> $past(det_active));

  a_r10_ext_no_pfm: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_active || det_active) |-> (pwm_only && !pfm_allowed));
endmodule

bind sync_tbase_sel sync_tbase_sel_chk #(.DIV(DIV), .WIN(WIN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cycle_tick     (cycle_tick),
  .ext_clk_active (ext_clk_active),
  .pwm_only       (pwm_only),
  .pfm_allowed    (pfm_allowed),
  .det_active     (det_active)
);

// File: tb/sync_tbase_sel_bench.sv
`timescale 1ns/1ps
module sync_tbase_sel_bench;
  localparam int DIV  = 22;
  localparam int WIN  = 64;
  localparam int MINE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_pin = 1'b0;
  logic cycle_tick, ext_clk_active, pwm_only, pfm_allowed;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ext_period = 0;
  logic pin_level = 1'b0;
  int phase = 0;

  always #2 clk = ~clk;

  sync_tbase_sel u_sync_tbase_sel (
    .clk (clk), .rst_n (rst_n), .sync_pin (sync_pin),
    .cycle_tick (cycle_tick), .ext_clk_active (ext_clk_active),
    .pwm_only (pwm_only), .pfm_allowed (pfm_allowed)
  );

  // pin driver, away from the active edge
  always @(negedge clk) begin
    if (ext_period > 0) begin
      sync_pin <= (phase < ext_period / 2);
      phase = (phase + 1 >= ext_period) ? 0 : phase + 1;
    end else begin
      sync_pin <= pin_level;
      phase = 0;
    end
  end

  // behavioural reference model
  int  hist[$];
  int  votes[$];
  int  m_win, m_edges, m_cnt;
  bit  m_act, m_sel, m_tick, m_maj;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {0, 0, 0};
      votes = {0, 0, 0};
      m_win = 0; m_edges = 0; m_cnt = 0;
      m_act = 0; m_sel = 0; m_tick = 0; m_maj = 0;
    end else begin
      int rise;
      bit adv;
      rise = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;          // R3
      adv = !m_sel || (rise == 1) || !m_act;                   // R7 R9
      m_tick = 0;
      if (adv) begin
        if (m_cnt == DIV - 1) begin
          m_tick = 1; m_cnt = 0; m_sel = m_act;                 // R8
        end else m_cnt++;
      end
      if (m_win == WIN - 1) begin                                // R4
        m_act = (m_edges + rise) >= MINE;
        m_edges = 0; m_win = 0;
      end else begin
        m_edges = (m_edges + rise > MINE) ? MINE : m_edges + rise;
        m_win++;
      end
      votes.push_front(hist[1]); void'(votes.pop_back());
      m_maj = (votes[0] + votes[1] + votes[2]) >= 2;             // R5
      hist.push_front(int'(sync_pin)); void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // compare with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_pwm;
      exp_pwm = m_act | m_sel | m_maj;
      chk(cycle_tick == m_tick, "R2/R7 cycle_tick vs model", cycle_tick, m_tick);
      chk(ext_clk_active == m_sel, "R11 ext_clk_active vs model", ext_clk_active, m_sel);
      chk(pwm_only == exp_pwm, "R5/R10 pwm_only vs model", pwm_only, exp_pwm);
      chk(pfm_allowed == !exp_pwm, "R6/R10 pfm_allowed vs model", pfm_allowed, !exp_pwm);
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_gap(output int g);
    do @(negedge clk); while (!cycle_tick);
    g = 0;
    do begin @(negedge clk); g++; end while (!cycle_tick);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    int g;
    wait_cycles(5);
    chk(cycle_tick == 0 && ext_clk_active == 0, "R1 reset tick/ext", cycle_tick + 2*ext_clk_active, 0);
    chk(pwm_only == 0 && pfm_allowed == 1, "R1 reset flags", pwm_only + 2*pfm_allowed, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cycle_tick == 0 && pfm_allowed == 1, "R1 after release", cycle_tick + 2*pfm_allowed, 2);

    // R2 internal period
    tick_gap(g);
    chk(g == DIV, "R2 internal tick spacing", g, DIV);

    // R5 steady high
    pin_level = 1'b1; wait_cycles(10);
    chk(pwm_only == 1 && pfm_allowed == 0, "R5 steady high flags", pwm_only + 2*pfm_allowed, 1);
    chk(ext_clk_active == 0, "R5 steady high keeps internal", ext_clk_active, 0);

    // R6 steady low
    pin_level = 1'b0; wait_cycles(10);
    chk(pwm_only == 0 && pfm_allowed == 1, "R6 steady low flags", pwm_only + 2*pfm_allowed, 2);

    // R7 external clock, period 6
    ext_period = 6; wait_cycles(200);
    chk(ext_clk_active == 1, "R11 external selected", ext_clk_active, 1);
    chk(pfm_allowed == 0 && pwm_only == 1, "R10 no PFM with clock", pfm_allowed, 0);
    tick_gap(g); tick_gap(g);
    chk(g == 22 * 6, "R7 external tick spacing p6", g, 22 * 6);

    // R4 boundary: exactly 4 edges per window
    ext_period = 16; wait_cycles(300);
    chk(ext_clk_active == 1, "R4 four edges per window present", ext_clk_active, 1);
    tick_gap(g);
    chk(g == 22 * 16, "R7 external tick spacing p16", g, 22 * 16);

    // R4 below threshold, R9 fallback
    ext_period = 24; wait_cycles(300);
    chk(ext_clk_active == 0, "R4 R9 slow clock not present", ext_clk_active, 0);
    tick_gap(g);
    chk(g == DIV, "R9 internal spacing after fallback", g, DIV);

    // R9 clock stops at high level
    ext_period = 6; wait_cycles(250);
    chk(ext_clk_active == 1, "R8 external again", ext_clk_active, 1);
    pin_level = 1'b1; ext_period = 0; wait_cycles(200);
    chk(ext_clk_active == 0, "R9 return to internal", ext_clk_active, 0);
    chk(pwm_only == 1, "R5 high after clock stop", pwm_only, 1);
    tick_gap(g);
    chk(g == DIV, "R9 internal spacing after stop", g, DIV);

    pin_level = 1'b0; wait_cycles(20);
    chk(pfm_allowed == 1, "R6 PFM allowed at end", pfm_allowed, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule